// File: doc/BRIEF.md
# Programmable Clock Phase Slip Adjuster

The block derives three sampling clocks from one master clock: a conversion strobe that is high for one master cycle per conversion period, a bit clock and a baud clock. It builds two independent copies of this divider chain. One is the receive set and one is the transmit set. Each set has its own phase adjust register. A 9-bit signed-magnitude value written there moves that clock set earlier (advance) or later (retard) by the programmed number of master clock periods. With the nominal 13.824 MHz master clock, one step is about 72 ns.

The correction is applied one master period at a time. On an advance, the conversion counter steps by two. On a retard, it holds for one master cycle. At most one such step is taken in each conversion period, and always at the counter's first count, so no strobe is lost or doubled. Every step lowers the register by one, and the register reads zero when the whole shift has been applied. A write only takes effect while the addressed register holds zero. Writes made during a shift are dropped.

The register port is a plain single-cycle write strobe with combinational read-back. It has no back-pressure: a write either lands in the cycle it is presented or it is discarded. The software sees whether a write landed by reading the register back or by watching the busy flag.

Top module: `clk_phase_slip`

## Requirements
- R1: A synchronous reset clears both adjust registers and all divider counters. After reset both registers read 0, busy and done are low, and the conversion strobe, bit clock and baud clock are low.
- R2: With no adjustment pending, each conversion strobe is high for one master cycle in every CONV_DIV cycles (master cycle n mod CONV_DIV = CONV_DIV-1, counting from reset). The bit clock has a period of CONV_DIV*CONVS_PER_BIT cycles and is high in its second half. The baud clock has a period of CONVS_PER_BIT*BITS_PER_BAUD conversion periods and is high in its second half.
- R3: The receive register is at address 4 and the transmit register at address 5. A read returns direction in bit 8 and magnitude in bits 7..0, with bits 15..9 zero. Any other address reads 0. A write whose bits 15..9 are not all zero is discarded.
- R4: A write to a register that holds a nonzero magnitude is discarded, and the countdown continues unchanged.
- R5: With bit 8 = 0 (advance), each step makes the set's strobe and clocks occur one master cycle earlier. A magnitude of M moves them M cycles earlier in total.
- R6: With bit 8 = 1 (retard), each step makes them occur one master cycle later. A magnitude of M moves them M cycles later in total.
- R7: At most one step is taken per conversion period, so the gap between successive strobes is always CONV_DIV-1, CONV_DIV or CONV_DIV+1 cycles.
- R8: Each step lowers the magnitude by exactly one. When it reaches zero, the register reads 0 and the direction bit is cleared.
- R9: Busy is high exactly while the magnitude is nonzero. Done is a one-cycle pulse in the first cycle the register reads zero after a countdown.
- R10: An accepted write with magnitude 0 leaves the register at 0 with direction cleared. It produces no step and no done pulse.
- R11: The two sets are independent. A write to one address never changes the other register or the other clock set, and both sets can shift at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address for write and read-back |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read-back of the addressed register |
| rx_conv_stb | output | 1 | Receive conversion strobe |
| rx_bit_clk | output | 1 | Receive bit clock |
| rx_baud_clk | output | 1 | Receive baud clock |
| rx_busy | output | 1 | Receive shift in progress |
| rx_done | output | 1 | Receive shift finished pulse |
| tx_conv_stb | output | 1 | Transmit conversion strobe |
| tx_bit_clk | output | 1 | Transmit bit clock |
| tx_baud_clk | output | 1 | Transmit baud clock |
| tx_busy | output | 1 | Transmit shift in progress |
| tx_done | output | 1 | Transmit shift finished pulse |

## Verification
An accepted write shows up on the read-back and on busy in the cycle after its rising edge. The first step then waits for the next first count of the conversion counter. Each step changes the clock outputs in the cycle after it is taken, because the outputs decode the counters with no further register. Done rises in the same cycle that the register first reads zero. The bench holds each stimulus across one rising edge, samples all outputs at the following falling edge, and compares them with a reference model advanced once per edge. It also measures the lag between the receive and transmit strobes to confirm the total shift.

// File: rtl/psa_pkg.sv
package psa_pkg;

  // kind of correction applied to the conversion counter on one master cycle
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADV  = 2'd1,
    CORR_RET  = 2'd2
  } corr_e;

  // counter increment that realises each correction kind
  function automatic logic [1:0] corr_step(corr_e kind);
    case (kind)
      CORR_ADV: corr_step = 2'd2;
      CORR_RET: corr_step = 2'd0;
      default:  corr_step = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/psa_adj_reg.sv
module psa_adj_reg #(
  parameter int MAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              apply,
  output logic [MAG_W-1:0]  mag,
  output logic              dir,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int RES_LO = MAG_W + 1;

  logic             resv_ok;
  logic             accept;
  logic [MAG_W-1:0] new_mag;
  logic             new_dir;
  logic             last_step;

  assign busy      = (mag != '0);
  assign resv_ok   = (wdata[DATA_W-1:RES_LO] == '0);
  assign accept    = wr_en && !busy && resv_ok;
  assign new_mag   = wdata[MAG_W-1:0];
  assign new_dir   = wdata[MAG_W] && (new_mag != '0);
  assign last_step = apply && (mag == MAG_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mag  <= '0;
      dir  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        mag <= new_mag;
        dir <= new_dir;
      end else if (apply) begin
        mag <= mag - MAG_W'(1);
        if (last_step) dir <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[MAG_W-1:0] = mag;
    rdata[MAG_W]     = dir;
  end

endmodule

// File: rtl/psa_div_chain.sv
module psa_div_chain
  import psa_pkg::*;
#(
  parameter int CONV_DIV      = 8,
  parameter int CONVS_PER_BIT = 4,
  parameter int BITS_PER_BAUD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic retard,
  output logic apply,
  output logic conv_stb,
  output logic bit_clk,
  output logic baud_clk
);
  localparam int CW = $clog2(CONV_DIV + 1);
  localparam int BW = $clog2(CONVS_PER_BIT + 1);
  localparam int DW = $clog2(BITS_PER_BAUD + 1);

  logic [CW-1:0] conv_cnt;
  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] baud_cnt;
  logic          slot_used;
  logic          conv_wrap;
  logic          bit_wrap;
  corr_e         kind;

  assign conv_wrap = (conv_cnt == CW'(CONV_DIV - 1));
  assign bit_wrap  = conv_wrap && (bit_cnt == BW'(CONVS_PER_BIT - 1));
  // one correction per conversion period, only at the first count
  assign apply     = req && (conv_cnt == '0) && !slot_used;

  always_comb begin
    if (!apply)      kind = CORR_NONE;
    else if (retard) kind = CORR_RET;
    else             kind = CORR_ADV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_cnt  <= '0;
      slot_used <= 1'b0;
    end else begin
      if (conv_wrap) conv_cnt <= '0;
      else           conv_cnt <= conv_cnt + CW'(corr_step(kind));
      if (apply)          slot_used <= 1'b1;
      else if (conv_wrap) slot_used <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      baud_cnt <= '0;
    end else if (conv_wrap) begin
      if (bit_wrap) begin
        bit_cnt <= '0;
        if (baud_cnt == DW'(BITS_PER_BAUD - 1)) baud_cnt <= '0;
        else                                    baud_cnt <= baud_cnt + DW'(1);
      end else begin
        bit_cnt <= bit_cnt + BW'(1);
      end
    end
  end

  assign conv_stb = conv_wrap;
  assign bit_clk  = (bit_cnt >= BW'(CONVS_PER_BIT / 2));
  assign baud_clk = (baud_cnt >= DW'(BITS_PER_BAUD / 2));

endmodule

// File: rtl/psa_channel.sv
module psa_channel #(
  parameter int MAG_W         = 8,
  parameter int DATA_W        = 16,
  parameter int CONV_DIV      = 8,
  parameter int CONVS_PER_BIT = 4,
  parameter int BITS_PER_BAUD = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [MAG_W-1:0]  mag,
  output logic              busy,
  output logic              done,
  output logic              conv_stb,
  output logic              bit_clk,
  output logic              baud_clk
);
  logic apply;
  logic dir;

  psa_adj_reg #(.MAG_W(MAG_W), .DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .apply(apply),
    .mag(mag), .dir(dir), .busy(busy), .done(done), .rdata(rdata)
  );

  psa_div_chain #(
    .CONV_DIV(CONV_DIV), .CONVS_PER_BIT(CONVS_PER_BIT), .BITS_PER_BAUD(BITS_PER_BAUD)
  ) u_div (
    .clk(clk), .rst(rst), .req(busy), .retard(dir), .apply(apply),
    .conv_stb(conv_stb), .bit_clk(bit_clk), .baud_clk(baud_clk)
  );

endmodule

// File: rtl/clk_phase_slip.sv
module clk_phase_slip #(
  parameter int              ADDR_W        = 4,
  parameter int              DATA_W        = 16,
  parameter int              MAG_W         = 8,
  parameter int              CONV_DIV      = 8,
  parameter int              CONVS_PER_BIT = 4,
  parameter int              BITS_PER_BAUD = 2,
  parameter logic [ADDR_W-1:0] RX_ADDR     = 4,
  parameter logic [ADDR_W-1:0] TX_ADDR     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_conv_stb,
  output logic              rx_bit_clk,
  output logic              rx_baud_clk,
  output logic              rx_busy,
  output logic              rx_done,
  output logic              tx_conv_stb,
  output logic              tx_bit_clk,
  output logic              tx_baud_clk,
  output logic              tx_busy,
  output logic              tx_done
);
  localparam int NCH = 2;
  localparam logic [NCH-1:0][ADDR_W-1:0] CH_ADDR = {TX_ADDR, RX_ADDR};

  logic [NCH-1:0]             ch_busy;
  logic [NCH-1:0]             ch_done;
  logic [NCH-1:0]             ch_stb;
  logic [NCH-1:0]             ch_bit;
  logic [NCH-1:0]             ch_baud;
  logic [NCH-1:0][MAG_W-1:0]  ch_mag;
  logic [NCH-1:0][DATA_W-1:0] ch_rdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_wr;
    assign hit_wr = reg_wr && (reg_addr == CH_ADDR[c]);

    psa_channel #(
      .MAG_W(MAG_W), .DATA_W(DATA_W), .CONV_DIV(CONV_DIV),
      .CONVS_PER_BIT(CONVS_PER_BIT), .BITS_PER_BAUD(BITS_PER_BAUD)
    ) u_ch (
      .clk(clk), .rst(rst), .wr_en(hit_wr), .wdata(reg_wdata),
      .rdata(ch_rdata[c]), .mag(ch_mag[c]), .busy(ch_busy[c]), .done(ch_done[c]),
      .conv_stb(ch_stb[c]), .bit_clk(ch_bit[c]), .baud_clk(ch_baud[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == CH_ADDR[c]) reg_rdata = ch_rdata[c];
    end
  end

  assign rx_conv_stb = ch_stb[0];
  assign rx_bit_clk  = ch_bit[0];
  assign rx_baud_clk = ch_baud[0];
  assign rx_busy     = ch_busy[0];
  assign rx_done     = ch_done[0];
  assign tx_conv_stb = ch_stb[1];
  assign tx_bit_clk  = ch_bit[1];
  assign tx_baud_clk = ch_baud[1];
  assign tx_busy     = ch_busy[1];
  assign tx_done     = ch_done[1];

endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int NCH   = 2,
  parameter int MAG_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            busy,
  input logic [NCH-1:0]            done,
  input logic [NCH-1:0]            stb,
  input logic [NCH-1:0][MAG_W-1:0] mag
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R1: reset leaves the magnitude at zero
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (mag[g] == '0));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done[g] |=> !done[g]);

    // R9: done only where a countdown has just ended
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
      done[g] |-> (!busy[g] && $past(busy[g])));

    // R7: the conversion strobe is never two cycles wide
    a_r7_stb_single: assert property (@(posedge clk) disable iff (rst)
      stb[g] |=> !stb[g]);

    // R8: a running countdown moves by at most one per cycle
    a_r8_count_by_one: assert property (@(posedge clk) disable iff (rst)
      ($past(mag[g]) != '0) |->
        ((mag[g] == $past(mag[g])) || (mag[g] == $past(mag[g]) - MAG_W'(1))));

    // R4: a busy register never grows, so no write lands in it
    a_r4_locked: assert property (@(posedge clk) disable iff (rst)
      busy[g] |=> (mag[g] <= $past(mag[g])));
  end
endmodule

bind clk_phase_slip psa_checker #(.NCH(2), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .busy(ch_busy), .done(ch_done), .stb(ch_stb), .mag(ch_mag)
);

// File: tb/sim_clk_phase_slip.sv
module sim_clk_phase_slip;
  localparam int CD  = 8;
  localparam int CPB = 4;
  localparam int BPB = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd4;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic rx_conv_stb, rx_bit_clk, rx_baud_clk, rx_busy, rx_done;
  logic tx_conv_stb, tx_bit_clk, tx_baud_clk, tx_busy, tx_done;

  always #5 clk = ~clk;

  clk_phase_slip u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rx_conv_stb(rx_conv_stb), .rx_bit_clk(rx_bit_clk), .rx_baud_clk(rx_baud_clk),
    .rx_busy(rx_busy), .rx_done(rx_done),
    .tx_conv_stb(tx_conv_stb), .tx_bit_clk(tx_bit_clk), .tx_baud_clk(tx_baud_clk),
    .tx_busy(tx_busy), .tx_done(tx_done)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state, one entry per clock set (0 receive, 1 transmit)
  int m_t[2], m_mag[2], m_dir[2], m_used[2], m_done[2], last_stb[2];
  int cyc = 0;
  int off_rx = 0, off_tx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int mod_cd(input int x);
    return ((x % CD) + CD) % CD;
  endfunction

  task automatic compare();
    logic [4:0] o [2];
    int exp_rd;
    o[0] = {rx_conv_stb, rx_bit_clk, rx_baud_clk, rx_busy, rx_done};
    o[1] = {tx_conv_stb, tx_bit_clk, tx_baud_clk, tx_busy, tx_done};
    for (int ch = 0; ch < 2; ch++) begin
      int e_stb, e_bit, e_baud;
      e_stb  = ((m_t[ch] % CD) == CD - 1) ? 1 : 0;
      e_bit  = (((m_t[ch] / CD) % CPB) >= CPB / 2) ? 1 : 0;
      e_baud = (((m_t[ch] / (CD * CPB)) % BPB) >= BPB / 2) ? 1 : 0;
      chk(o[ch][4] == e_stb,  {"R2 strobe ", tag}, o[ch][4], e_stb);
      chk(o[ch][3] == e_bit,  {"R2 bit clock ", tag}, o[ch][3], e_bit);
      chk(o[ch][2] == e_baud, {"R2 baud clock ", tag}, o[ch][2], e_baud);
      chk(o[ch][1] == (m_mag[ch] != 0), {"R9 busy ", tag}, o[ch][1], int'(m_mag[ch] != 0));
      chk(o[ch][0] == m_done[ch], {"R9 done ", tag}, o[ch][0], m_done[ch]);
      if (o[ch][4] && !rst) begin
        if (last_stb[ch] >= 0)
          chk((cyc - last_stb[ch] >= CD - 1) && (cyc - last_stb[ch] <= CD + 1),
              "R7 strobe gap", cyc - last_stb[ch], CD);
        last_stb[ch] = cyc;
      end
    end
    exp_rd = 0;
    if (reg_addr == 4'd4) exp_rd = (m_dir[0] << 8) | m_mag[0];
    if (reg_addr == 4'd5) exp_rd = (m_dir[1] << 8) | m_mag[1];
    chk(int'(reg_rdata) == exp_rd, {"R3 read-back ", tag}, int'(reg_rdata), exp_rd);
  endtask

  // drive one cycle of stimulus, advance the model, sample at the falling edge
  task automatic step(input bit wr, input logic [3:0] a, input logic [15:0] d);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    for (int ch = 0; ch < 2; ch++) begin
      if (rst) begin
        m_t[ch] = 0; m_mag[ch] = 0; m_dir[ch] = 0; m_used[ch] = 0; m_done[ch] = 0;
        last_stb[ch] = -1;
      end else begin
        int ph; bit ap; bit wok;
        ph  = m_t[ch] % CD;
        ap  = (m_mag[ch] != 0) && (ph == 0) && (m_used[ch] == 0);
        wok = wr && (int'(a) == 4 + ch) && (m_mag[ch] == 0) && (d[15:9] == 0);
        m_done[ch] = (ap && m_mag[ch] == 1) ? 1 : 0;
        if (ap) m_used[ch] = 1; else if (ph == CD - 1) m_used[ch] = 0;
        if (ap) m_t[ch] = m_dir[ch] ? m_t[ch] : m_t[ch] + 2;
        else    m_t[ch] = m_t[ch] + 1;
        if (wok) begin
          m_mag[ch] = int'(d[7:0]);
          m_dir[ch] = (d[7:0] != 0) ? int'(d[8]) : 0;
        end else if (ap) begin
          if (m_mag[ch] == 1) m_dir[ch] = 0;
          m_mag[ch] = m_mag[ch] - 1;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    reg_wr = 1'b0;
    compare();
  endtask

  task automatic idle(input int n, input logic [3:0] a);
    for (int i = 0; i < n; i++) step(1'b0, a, 16'h0);
  endtask

  task automatic wait_quiet(input logic [3:0] a);
    int n = 0;
    while ((rx_busy || tx_busy) && n < 5000) begin
      step(1'b0, a, 16'h0);
      n++;
    end
    idle(2 * CD, a);
  endtask

  // cycles from a receive strobe to the next transmit strobe
  task automatic measure(output int lag);
    int n = 0;
    while (!rx_conv_stb && n < 100) begin step(1'b0, 4'd4, 16'h0); n++; end
    lag = 0;
    while (!tx_conv_stb && lag < 100) begin step(1'b0, 4'd4, 16'h0); lag++; end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lag;
    @(negedge clk);
    tag = "R1";
    rst = 1'b1;
    idle(3, 4'd4);
    rst = 1'b0;
    step(1'b0, 4'd4, 16'h0);
    chk(reg_rdata == 16'h0, "R1 rx register after reset", reg_rdata, 0);
    step(1'b0, 4'd5, 16'h0);
    chk(reg_rdata == 16'h0, "R1 tx register after reset", reg_rdata, 0);
    chk(!rx_busy && !tx_busy, "R1 busy after reset", rx_busy, 0);

    tag = "R2";
    idle(80, 4'd5);
    measure(lag);
    chk(lag == 0, "R2 sets aligned with no adjustment", lag, 0);

    tag = "R3";
    step(1'b1, 4'd4, 16'hFE03);
    idle(3, 4'd4);
    chk(reg_rdata == 16'h0 && !rx_busy, "R3 reserved bits set discards write", reg_rdata, 0);
    step(1'b1, 4'd7, 16'h0003);
    chk(reg_rdata == 16'h0, "R3 unmapped address reads zero", reg_rdata, 0);

    tag = "R4";
    step(1'b1, 4'd4, 16'h0003);
    off_rx += 3;
    chk(reg_rdata == 16'h0003, "R3 accepted write reads back", reg_rdata, 3);
    step(1'b1, 4'd4, 16'h0105);
    chk(reg_rdata[8] == 1'b0 && reg_rdata[7:0] <= 8'd3, "R4 write while busy discarded",
        reg_rdata, 3);

    tag = "R8";
    wait_quiet(4'd4);
    chk(reg_rdata == 16'h0, "R8 register zero after countdown", reg_rdata, 0);
    measure(lag);
    chk(lag == mod_cd(off_rx - off_tx), "R5 advance moves receive set earlier", lag,
        mod_cd(off_rx - off_tx));

    tag = "R6";
    step(1'b1, 4'd5, 16'h0102);
    off_tx -= 2;
    chk(reg_rdata == 16'h0102, "R6 retard value reads back", reg_rdata, 16'h0102);
    wait_quiet(4'd5);
    chk(reg_rdata == 16'h0, "R8 direction cleared at zero", reg_rdata, 0);
    measure(lag);
    chk(lag == mod_cd(off_rx - off_tx), "R6 retard moves transmit set later", lag,
        mod_cd(off_rx - off_tx));

    tag = "R11";
    step(1'b1, 4'd4, 16'h0104);
    off_rx -= 4;
    step(1'b1, 4'd5, 16'h0001);
    off_tx += 1;
    chk(rx_busy && tx_busy, "R11 both sets shift together", {rx_busy, tx_busy}, 3);
    step(1'b0, 4'd4, 16'h0);
    chk(reg_rdata[8] == 1'b1, "R11 transmit write leaves receive register", reg_rdata, 16'h0104);
    wait_quiet(4'd4);
    measure(lag);
    chk(lag == mod_cd(off_rx - off_tx), "R11 independent shifts", lag, mod_cd(off_rx - off_tx));

    tag = "R10";
    step(1'b1, 4'd4, 16'h0100);
    chk(reg_rdata == 16'h0 && !rx_busy, "R10 zero magnitude clears direction", reg_rdata, 0);
    idle(2 * CD, 4'd4);
    measure(lag);
    chk(lag == mod_cd(off_rx - off_tx), "R10 zero magnitude makes no shift", lag,
        mod_cd(off_rx - off_tx));

    tag = "R7";
    step(1'b1, 4'd4, 16'h01FF);
    off_rx -= 255;
    chk(reg_rdata == 16'h01FF, "R7 full magnitude retard accepted", reg_rdata, 16'h01FF);
    wait_quiet(4'd4);
    measure(lag);
    chk(lag == mod_cd(off_rx - off_tx), "R6 full magnitude retard total", lag,
        mod_cd(off_rx - off_tx));

    tag = "R5";
    step(1'b1, 4'd5, 16'h00FF);
    off_tx += 255;
    wait_quiet(4'd5);
    measure(lag);
    chk(lag == mod_cd(off_rx - off_tx), "R5 full magnitude advance total", lag,
        mod_cd(off_rx - off_tx));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule